// File: doc/BRIEF.md
# Way-Predicting Pseudo-Associative Read Cache

This block is a two-way set-associative read cache that looks at one way at a time rather than comparing both ways together. Each request first probes a single way, chosen either by a small per-set prediction table or always way 0, as a parameter selects. If that probe finds the line, the access finishes one cycle after acceptance as a fast hit. Otherwise the other way is probed in the next cycle. A match there is a pseudo-hit and finishes three cycles after acceptance. If neither way holds the line, it is fetched through a simple memory request/response port, written into the way that was not predicted, and returned as a miss.

Only the probed way's arrays are read in any probe cycle, and this is visible as a per-way read-enable output. The block accepts one request at a time. Its ready output stays low from acceptance until the response.

Top module: `wpcache_top`

## Requirements
- R1: After reset, req_ready is 1 and resp_valid, way_rd_en and mem_req_valid are 0. All valid bits and predictor entries are cleared, so the first access to any address after reset is a miss whose first probe is way 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the cycle after acceptance through the response cycle and is 1 again in the cycle after the response. resp_valid lasts exactly one cycle.
- R3: A match in the first-probed way gives resp_valid exactly 1 cycle after acceptance, with resp_kind 2'b00 and resp_data holding the addressed word.
- R4: A match found only in the second probe gives resp_valid exactly 3 cycles after acceptance, with resp_kind 2'b01 and the addressed word.
- R5: When both ways miss, mem_req_valid is raised with mem_req_line equal to req_addr without its offset bits (req_addr[11:1] at defaults). It is held stable until mem_req_ready. One cycle after mem_resp_valid, the response gives resp_kind 2'b10 and the word selected by the offset (word 0 in bits [DATA_W-1:0] of mem_resp_line).
- R6: In each probe cycle exactly one bit of way_rd_en is 1 (bit 0 is way 0). In the cycle after acceptance it names the first-probed way. While the block is idle it is 0.
- R7: After a pseudo-hit, the predictor entry for that set names the way that matched, so repeating the access is a fast hit.
- R8: A refill replaces the way that was not predicted and then sets the predictor to the refilled way. The line in the predicted way survives, and re-accessing the refilled line is a fast hit.
- R9: With PRED_EN = 0, the first probe is always way 0. A line held in way 1 therefore gives a pseudo-hit on every access. The victim is still the way the table does not name, and the table is updated as in R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | CPU read request present |
| req_addr | input | ADDR_W | Word address of the request |
| req_ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | Response present (one cycle) |
| resp_data | output | DATA_W | Returned word |
| resp_kind | output | 2 | 00 hit, 01 pseudo-hit, 10 miss-filled |
| way_rd_en | output | 2 | Per-way array read enable |
| mem_req_valid | output | 1 | Line fetch request |
| mem_req_ready | input | 1 | Memory takes the fetch request |
| mem_req_line | output | ADDR_W-OFF_W | Line address to fetch |
| mem_resp_valid | input | 1 | Fetched line present |
| mem_resp_line | input | DATA_W*2**OFF_W | Fetched line, word 0 in the low bits |

## Verification
Two things can fall in the same cycle. One is the predictor update from a pseudo-hit or a refill. The other is a request already waiting at the input, whose first probe must use that freshly updated entry. The bench holds req_valid high through every access and issues follow-up requests to the same set straight after the response. It then judges which way_rd_en bit is raised in the first probe cycle, and whether the outcome is a fast hit or a pseudo-hit with its exact latency. A replayed sequence that fills, evicts and refills one set shows whether the victim choice spares the predicted way.

// File: rtl/wpc_pkg.sv
// Shared types for the way-predicting cache: response outcome codes and
// controller states. Assumes a two-way organisation throughout.
package wpc_pkg;
    typedef enum logic [1:0] {
        KIND_HIT  = 2'b00,
        KIND_PHIT = 2'b01,
        KIND_MISS = 2'b10
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE1,
        ST_PROBE2,
        ST_PHIT,
        ST_MREQ,
        ST_MWAIT,
        ST_MRESP
    } state_e;
endpackage

// File: rtl/wpc_way_store.sv
// One cache way: valid bits, tags and line data for every set.
// Reads are combinational and gated by rd_en, so a disabled way can
// never report a match. Assumes a fill never coincides with a probe.
module wpc_way_store #(
    parameter int SET_W  = 3,
    parameter int TAG_W  = 8,
    parameter int OFF_W  = 1,
    parameter int DATA_W = 32,
    localparam int SETS  = 1 << SET_W,
    localparam int WORDS = 1 << OFF_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [SET_W-1:0]             rd_set,
    input  logic [TAG_W-1:0]             rd_tag,
    input  logic [OFF_W-1:0]             rd_off,
    output logic                         hit,
    output logic [DATA_W-1:0]            rd_word,
    input  logic                         wr_en,
    input  logic [SET_W-1:0]             wr_set,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [WORDS-1:0][DATA_W-1:0] wr_line
);
    logic [SETS-1:0]                     valid_q;
    logic [TAG_W-1:0]                    tag_q  [SETS];
    logic [WORDS-1:0][DATA_W-1:0]        line_q [SETS];

    // Valid bits: cleared by reset, set when a line is filled.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else if (wr_en) valid_q[wr_set] <= 1'b1;
    end

    // Tag and data storage: written on fill only.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set]  <= wr_tag;
            line_q[wr_set] <= wr_line;
        end
    end

    // Gated probe: match and word only when this way is enabled.
    always_comb begin
        hit     = rd_en && valid_q[rd_set] && (tag_q[rd_set] == rd_tag);
        rd_word = rd_en ? line_q[rd_set][rd_off] : '0;
    end

    AST_FILL_NO_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rd_en); // R6
endmodule

// File: rtl/wpc_predictor.sv
// Per-set way prediction table. Gives the first way to probe (the
// table entry, or way 0 when PRED_EN is 0) and the victim way (the way
// the entry does not name). Entries reset to way 0.
module wpc_predictor #(
    parameter int SET_W   = 3,
    parameter bit PRED_EN = 1'b1,
    localparam int SETS   = 1 << SET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output logic             first_way,
    output logic             victim_way,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic             upd_way
);
    logic [SETS-1:0] tbl_q;

    // Table update on pseudo-hit or refill.
    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else if (upd_en) tbl_q[upd_set] <= upd_way;
    end

    generate
        if (PRED_EN) begin : g_pred
            // Predicted order: probe the way the table names.
            always_comb first_way = tbl_q[rd_set];
        end else begin : g_fixed
            // Fixed order: way 0 always first.
            always_comb first_way = 1'b0;
        end
    endgenerate

    // Victim is the way the table does not name.
    always_comb victim_way = ~tbl_q[rd_set];
endmodule

// File: rtl/wpc_ctrl.sv
// Probe sequencer: accepts one request, probes the first way, then the
// other, then fetches and fills on a full miss. Holds the request
// address and the word returned for slow outcomes.
module wpc_ctrl
    import wpc_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int SET_W   = 3,
    parameter int OFF_W   = 1,
    parameter int DATA_W  = 32,
    localparam int WORDS  = 1 << OFF_W,
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W,
    localparam int LADDR_W = ADDR_W - OFF_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [ADDR_W-1:0]            req_addr,
    output logic                         req_ready,
    output logic                         resp_valid,
    output logic [DATA_W-1:0]            resp_data,
    output kind_e                        resp_kind,
    output logic [1:0]                   rd_en,
    output logic [1:0]                   wr_en,
    input  logic                         hit_any,
    input  logic [DATA_W-1:0]            probe_word,
    output logic [SET_W-1:0]             cur_set,
    output logic [TAG_W-1:0]             cur_tag,
    output logic [OFF_W-1:0]             cur_off,
    input  logic                         first_way,
    input  logic                         victim_way,
    output logic                         pred_upd,
    output logic                         pred_way,
    output logic                         mem_req_valid,
    input  logic                         mem_req_ready,
    output logic [LADDR_W-1:0]           mem_req_line,
    input  logic                         mem_resp_valid,
    input  logic [WORDS-1:0][DATA_W-1:0] mem_resp_line
);
    state_e              state_q, state_d;
    logic [ADDR_W-1:0]   addr_q;
    logic                first_q;
    logic [DATA_W-1:0]   hold_q;

    always_comb begin
        cur_off      = addr_q[OFF_W-1:0];
        cur_set      = addr_q[OFF_W+SET_W-1:OFF_W];
        cur_tag      = addr_q[ADDR_W-1:OFF_W+SET_W];
        mem_req_line = addr_q[ADDR_W-1:OFF_W];
    end

    // Next state and per-state outputs.
    always_comb begin
        state_d       = state_q;
        req_ready     = 1'b0;
        rd_en         = '0;
        wr_en         = '0;
        pred_upd      = 1'b0;
        pred_way      = 1'b0;
        mem_req_valid = 1'b0;
        resp_valid    = 1'b0;
        resp_kind     = KIND_HIT;
        resp_data     = hold_q;
        case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) state_d = ST_PROBE1;
            end
            ST_PROBE1: begin
                rd_en[first_way] = 1'b1;
                if (hit_any) begin
                    resp_valid = 1'b1;
                    resp_data  = probe_word;
                    state_d    = ST_IDLE;
                end else begin
                    state_d = ST_PROBE2;
                end
            end
            ST_PROBE2: begin
                rd_en[~first_q] = 1'b1;
                if (hit_any) begin
                    pred_upd = 1'b1;
                    pred_way = ~first_q;
                    state_d  = ST_PHIT;
                end else begin
                    state_d = ST_MREQ;
                end
            end
            ST_PHIT: begin
                resp_valid = 1'b1;
                resp_kind  = KIND_PHIT;
                state_d    = ST_IDLE;
            end
            ST_MREQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) state_d = ST_MWAIT;
            end
            ST_MWAIT: begin
                if (mem_resp_valid) begin
                    wr_en[victim_way] = 1'b1;
                    pred_upd = 1'b1;
                    pred_way = victim_way;
                    state_d  = ST_MRESP;
                end
            end
            ST_MRESP: begin
                resp_valid = 1'b1;
                resp_kind  = KIND_MISS;
                state_d    = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else state_q <= state_d;
    end

    // Request address, first-probed way and held response word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            first_q <= 1'b0;
            hold_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) addr_q <= req_addr;
            if (state_q == ST_PROBE1) first_q <= first_way;
            if (state_q == ST_PROBE2 && hit_any) hold_q <= probe_word;
            if (state_q == ST_MWAIT && mem_resp_valid) hold_q <= mem_resp_line[cur_off];
        end
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2
    AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R2
    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == KIND_HIT) |-> $past(req_valid && req_ready)); // R3
    AST_PHIT_THREE_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == KIND_PHIT) |-> $past(req_valid && req_ready, 3)); // R4
    AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_line))); // R5
endmodule

// File: rtl/wpcache_top.sv
// Two-way pseudo-associative read cache. Probes one way per cycle in
// predicted (or fixed) order; full misses fetch a whole line from
// memory in one response beat. One request outstanding at a time.
// Assumes OFF_W >= 1 (at least two words per line).
module wpcache_top #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int SET_W   = 3,
    parameter int OFF_W   = 1,
    parameter bit PRED_EN = 1'b1,
    localparam int WORDS   = 1 << OFF_W,
    localparam int TAG_W   = ADDR_W - SET_W - OFF_W,
    localparam int LADDR_W = ADDR_W - OFF_W,
    localparam int LINE_W  = DATA_W * WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_ready,
    output logic               resp_valid,
    output logic [DATA_W-1:0]  resp_data,
    output logic [1:0]         resp_kind,
    output logic [1:0]         way_rd_en,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [LADDR_W-1:0] mem_req_line,
    input  logic               mem_resp_valid,
    input  logic [LINE_W-1:0]  mem_resp_line
);
    import wpc_pkg::*;

    logic [1:0]                   rd_en, wr_en, way_hit;
    logic [DATA_W-1:0]            way_word [2];
    logic [DATA_W-1:0]            probe_word;
    logic                         hit_any;
    logic [SET_W-1:0]             cur_set;
    logic [TAG_W-1:0]             cur_tag;
    logic [OFF_W-1:0]             cur_off;
    logic                         first_way, victim_way, pred_upd, pred_way;
    logic [WORDS-1:0][DATA_W-1:0] fill_line;
    kind_e                        kind;

    // Merge gated way outputs; at most one way is enabled.
    always_comb begin
        fill_line  = mem_resp_line;
        probe_word = way_word[0] | way_word[1];
        hit_any    = |way_hit;
        way_rd_en  = rd_en;
        resp_kind  = kind;
    end

    generate
        for (genvar w = 0; w < 2; w++) begin : g_way
            wpc_way_store #(
                .SET_W(SET_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
            ) u_way (
                .clk(clk), .rst_n(rst_n),
                .rd_en(rd_en[w]), .rd_set(cur_set), .rd_tag(cur_tag), .rd_off(cur_off),
                .hit(way_hit[w]), .rd_word(way_word[w]),
                .wr_en(wr_en[w]), .wr_set(cur_set), .wr_tag(cur_tag), .wr_line(fill_line)
            );
        end
    endgenerate

    wpc_predictor #(.SET_W(SET_W), .PRED_EN(PRED_EN)) u_pred (
        .clk(clk), .rst_n(rst_n), .rd_set(cur_set),
        .first_way(first_way), .victim_way(victim_way),
        .upd_en(pred_upd), .upd_set(cur_set), .upd_way(pred_way)
    );

    wpc_ctrl #(
        .ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_kind(kind),
        .rd_en(rd_en), .wr_en(wr_en), .hit_any(hit_any), .probe_word(probe_word),
        .cur_set(cur_set), .cur_tag(cur_tag), .cur_off(cur_off),
        .first_way(first_way), .victim_way(victim_way),
        .pred_upd(pred_upd), .pred_way(pred_way),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_line(mem_req_line), .mem_resp_valid(mem_resp_valid),
        .mem_resp_line(fill_line)
    );

    AST_NO_PROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (way_rd_en == 2'b00)); // R6
    AST_PROBE_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> $onehot(way_rd_en)); // R6
endmodule

// File: tb/wpcache_top_test.sv
// Line memory model: after STALL cycles of a pending request it takes the
// request, then returns the line LAT cycles later. Word w of line L holds
// 32'h5A5A0000 | (L*WORDS + w).
module wpc_mem_model #(
    parameter int LADDR_W = 11,
    parameter int DATA_W  = 32,
    parameter int WORDS   = 2,
    parameter int STALL   = 2,
    parameter int LAT     = 2
) (
    input  logic                      clk,
    input  logic                      req_valid,
    input  logic [LADDR_W-1:0]        req_line,
    output logic                      req_ready,
    output logic                      resp_valid,
    output logic [DATA_W*WORDS-1:0]   resp_line
);
    initial begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        resp_line  = '0;
        forever begin
            @(negedge clk);
            if (req_valid) begin
                repeat (STALL) @(negedge clk);
                for (int w = 0; w < WORDS; w++)
                    resp_line[w*DATA_W +: DATA_W] = 32'h5A5A0000 | (int'(req_line) * WORDS + w);
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
                repeat (LAT) @(negedge clk);
                resp_valid = 1'b1;
                @(negedge clk);
                resp_valid = 1'b0;
            end
        end
    end
endmodule

module wpcache_top_test;
    localparam int AW = 12;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    // Predicting instance signals.
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          req_ready, resp_valid, mem_req_valid, mem_req_ready, mem_resp_valid;
    logic [DW-1:0] resp_data;
    logic [1:0]    resp_kind, way_rd_en;
    logic [AW-2:0] mem_req_line;
    logic [2*DW-1:0] mem_resp_line;
    // Fixed-order instance signals.
    logic          f_req_valid;
    logic [AW-1:0] f_req_addr;
    logic          f_req_ready, f_resp_valid, f_mem_req_valid, f_mem_req_ready, f_mem_resp_valid;
    logic [DW-1:0] f_resp_data;
    logic [1:0]    f_resp_kind, f_way_rd_en;
    logic [AW-2:0] f_mem_req_line;
    logic [2*DW-1:0] f_mem_resp_line;

    wpcache_top #(.PRED_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .resp_kind(resp_kind), .way_rd_en(way_rd_en), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_line(mem_req_line),
        .mem_resp_valid(mem_resp_valid), .mem_resp_line(mem_resp_line));

    wpcache_top #(.PRED_EN(1'b0)) uut_fixed (
        .clk(clk), .rst_n(rst_n), .req_valid(f_req_valid), .req_addr(f_req_addr),
        .req_ready(f_req_ready), .resp_valid(f_resp_valid), .resp_data(f_resp_data),
        .resp_kind(f_resp_kind), .way_rd_en(f_way_rd_en), .mem_req_valid(f_mem_req_valid),
        .mem_req_ready(f_mem_req_ready), .mem_req_line(f_mem_req_line),
        .mem_resp_valid(f_mem_resp_valid), .mem_resp_line(f_mem_resp_line));

    wpc_mem_model u_mem (.clk(clk), .req_valid(mem_req_valid), .req_line(mem_req_line),
        .req_ready(mem_req_ready), .resp_valid(mem_resp_valid), .resp_line(mem_resp_line));
    wpc_mem_model u_fmem (.clk(clk), .req_valid(f_mem_req_valid), .req_line(f_mem_req_line),
        .req_ready(f_mem_req_ready), .resp_valid(f_mem_resp_valid), .resp_line(f_mem_resp_line));

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Sampled view of whichever instance is under test.
    logic          s_ready, s_rvalid, s_mvalid;
    logic [1:0]    s_kind, s_rden;
    logic [DW-1:0] s_data;
    logic [AW-2:0] s_mline;

    task automatic snap(input bit fx);
        s_ready  = fx ? f_req_ready     : req_ready;
        s_rvalid = fx ? f_resp_valid    : resp_valid;
        s_mvalid = fx ? f_mem_req_valid : mem_req_valid;
        s_kind   = fx ? f_resp_kind     : resp_kind;
        s_rden   = fx ? f_way_rd_en     : way_rd_en;
        s_data   = fx ? f_resp_data     : resp_data;
        s_mline  = fx ? f_mem_req_line  : mem_req_line;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit fx, input bit v, input logic [AW-1:0] a);
        if (fx) begin f_req_valid = v; f_req_addr = a; end
        else begin req_valid = v; req_addr = a; end
    endtask

    // One access: request held valid until the response, then checked.
    task automatic do_access(input bit fx, input logic [AW-1:0] a, input logic [1:0] ek,
                             input bit ew, input string req);
        int lat;
        string kreq;
        kreq = (ek == 2'b00) ? "R3" : (ek == 2'b01) ? "R4" : "R5";
        @(negedge clk);
        snap(fx);
        check(s_ready == 1'b1, "R2", "ready before request", 32'(s_ready), 32'd1);
        drive(fx, 1'b1, a);
        @(negedge clk);
        lat = 1;
        snap(fx);
        check(s_ready == 1'b0, "R2", "ready after accept", 32'(s_ready), 32'd0);
        check(s_rden == (ew ? 2'b10 : 2'b01), fx ? "R9" : "R6", {req, " first probe way"},
              32'(s_rden), ew ? 32'd2 : 32'd1);
        while (!s_rvalid && lat < 60) begin
            @(negedge clk);
            lat++;
            snap(fx);
            if (lat == 3 && ek == 2'b10)
                check(s_mvalid && s_mline == a[AW-1:1], "R5", "fetch line address",
                      32'(s_mline), 32'(a[AW-1:1]));
            if (!s_rvalid)
                check(s_ready == 1'b0, "R2", "ready while busy", 32'(s_ready), 32'd0);
        end
        drive(fx, 1'b0, a);
        check(s_kind == ek, req, {kreq, " outcome code"}, 32'(s_kind), 32'(ek));
        check(s_data == (32'h5A5A0000 | 32'(a)), req, {kreq, " data"}, s_data,
              32'h5A5A0000 | 32'(a));
        if (ek == 2'b00) check(lat == 1, "R3", "hit latency", 32'(lat), 32'd1);
        if (ek == 2'b01) check(lat == 3, "R4", "pseudo-hit latency", 32'(lat), 32'd3);
        if (ek == 2'b10) check(lat >= 4 && lat < 60, "R5", "miss completes", 32'(lat), 32'd4);
        @(negedge clk);
        snap(fx);
        check(s_ready == 1'b1 && s_rvalid == 1'b0, "R2", "ready after response",
              {30'd0, s_ready, s_rvalid}, 32'd2);
    endtask

    // Vector: {address, outcome, first way, requirement number}.
    localparam int NV = 13;
    localparam logic [18:0] VEC [NV] = '{
        {12'h014, 2'b10, 1'b0, 4'd5},  // R5 cold miss, fill way 1
        {12'h015, 2'b00, 1'b1, 4'd8},  // R8 refilled line is now predicted
        {12'h025, 2'b10, 1'b1, 4'd5},  // R5 miss, victim way 0
        {12'h014, 2'b01, 1'b0, 4'd4},  // R4 pseudo-hit in way 1
        {12'h014, 2'b00, 1'b1, 4'd7},  // R7 predictor moved to way 1
        {12'h025, 2'b01, 1'b1, 4'd4},  // R4 pseudo-hit in way 0
        {12'h034, 2'b10, 1'b0, 4'd8},  // R8 victim way 1 (not predicted)
        {12'h025, 2'b01, 1'b1, 4'd8},  // R8 predicted-way line survived
        {12'h034, 2'b01, 1'b0, 4'd4},  // R4
        {12'h014, 2'b10, 1'b1, 4'd5},  // R5 evicts way 0
        {12'h034, 2'b01, 1'b0, 4'd7},  // R7
        {12'h0AA, 2'b10, 1'b0, 4'd5},  // R5 other set
        {12'h0AB, 2'b00, 1'b1, 4'd3}   // R3 fast hit, word 1
    };
    localparam int NF = 6;
    localparam logic [14:0] FVEC [NF] = '{
        {12'h014, 2'b10, 1'b0},  // R9 miss, fill way 1
        {12'h014, 2'b01, 1'b0},  // R9 way 0 probed first again
        {12'h015, 2'b01, 1'b0},  // R9 still pseudo-hit
        {12'h025, 2'b10, 1'b0},  // R9 victim way 0
        {12'h025, 2'b00, 1'b0},  // R9 fast hit in way 0
        {12'h014, 2'b01, 1'b0}   // R9
    };

    task automatic check_reset_state();
        @(negedge clk);
        snap(1'b0);
        check(s_ready == 1'b1, "R1", "ready after reset", 32'(s_ready), 32'd1);
        check(s_rvalid == 1'b0, "R1", "resp_valid after reset", 32'(s_rvalid), 32'd0);
        check(s_rden == 2'b00, "R1", "way_rd_en after reset", 32'(s_rden), 32'd0);
        check(s_mvalid == 1'b0, "R1", "mem_req_valid after reset", 32'(s_mvalid), 32'd0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        drive(1'b0, 1'b0, '0);
        drive(1'b1, 1'b0, '0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_reset_state();
        for (int i = 0; i < NV; i++)
            do_access(1'b0, VEC[i][18:7], VEC[i][6:5], VEC[i][4], $sformatf("R%0d", VEC[i][3:0]));
        for (int i = 0; i < NF; i++)
            do_access(1'b1, FVEC[i][14:3], FVEC[i][2:1], FVEC[i][0], "R9");
        // R1: reset mid-run clears valid bits and the predictor.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_reset_state();
        do_access(1'b0, 12'h014, 2'b10, 1'b0, "R1");
        do_access(1'b0, 12'h025, 2'b10, 1'b1, "R1");
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule